// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using what recent branches did. A shift register keeps the directions of the last few resolved branches. That history is joined with a few low bits of the branch address to pick one saturating counter from a table. The top bit of that counter is the guess.

The block has two ports. The fetch side presents a branch address and gets a taken or not-taken guess back in the same cycle, with no clock edge in between. The resolve side reports a branch address and its real direction. On the next clock edge that report moves the selected counter one step toward the real direction and shifts the direction into the history. A pattern that repeats, such as a branch that alternates, ends up training a different counter for each history value. The guess therefore follows the pattern instead of a single average per branch.

Top module: `bp_predictor`

## Requirements
- R1: Reset is synchronous and active high. It clears the history to all not-taken and sets every counter to 0. After reset, every address is predicted not taken.
- R2: `pred_taken` is the most significant bit of the selected CTR_W-bit counter. With CTR_W=2, counter values 2 and 3 predict taken and values 0 and 1 predict not taken.
- R3: A taken update adds one to the selected counter, and it stays at 2^CTR_W-1 once there. A not-taken update subtracts one, and it stays at 0 once there.
- R4: The prediction depends on exactly the last HIST_W resolved outcomes. Each valid update shifts the history left, with the new outcome entering bit 0 (taken = 1). Outcomes older than HIST_W updates have no effect.
- R5: The counter index is {address[IDX_W-1:0], history} when USE_ADDR=1. Addresses with different low IDX_W bits use separate counters. Addresses that share those low bits share counters.
- R6: When a prediction and an update select the same counter in the same cycle, the prediction shows the counter value from before the update.
- R7: While `upd_valid` is low, neither the history nor any counter changes, whatever `upd_pc` and `upd_taken` hold.
- R8: For a branch that alternates taken and not taken, the two history values 1010 and 0101 train two distinct counters. After a few rounds, every outcome of the pattern is predicted correctly.
- R9: The prediction follows `pred_pc` within the same cycle, with no clock edge between the address and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction, 1 = taken |

## Verification
The first pattern is a strictly alternating taken/not-taken stream. It separates a history-selected counter from a per-branch counter: only the former reaches correct predictions on both phases. Runs of taken outcomes, each followed by exactly HIST_W not-taken outcomes, bring the history back to zero. These runs repeatedly hit one counter, which exposes saturation at both ends and shows that older outcomes drop out of the window. A second address with other low bits, and a third that aliases the second, show separation and sharing of counters. Invalid update strobes and a predict-while-updating collision complete the set.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;

  function automatic int unsigned table_aw(input int unsigned idx_w,
                                           input int unsigned hist_w,
                                           input bit use_addr);
    return use_addr ? (idx_w + hist_w) : hist_w;
  endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int unsigned HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= {hist_q[HIST_W-2:0], outcome};
    end
  end

endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PC_W     = 8,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned HIST_W   = 4,
  parameter bit          USE_ADDR = 1'b1,
  localparam int unsigned AW      = bp_pkg::table_aw(IDX_W, HIST_W, USE_ADDR)
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [AW-1:0]     idx
);

  logic unused_pc_bits;
  assign unused_pc_bits = ^pc;

  generate
    if (USE_ADDR) begin : g_addr_hist
      assign idx = {pc[IDX_W-1:0], hist};
    end else begin : g_hist_only
      assign idx = hist;
    end
  endgenerate

endmodule

// File: rtl/bp_sat_counter.sv
module bp_sat_counter #(
  parameter int unsigned CTR_W = 2
) (
  input  logic [CTR_W-1:0] ctr,
  input  logic             taken,
  output logic [CTR_W-1:0] ctr_next
);

  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;
  localparam logic [CTR_W-1:0] ONE     = {{(CTR_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (taken) begin
      ctr_next = (ctr == CTR_MAX) ? ctr : ctr + ONE;
    end else begin
      ctr_next = (ctr == CTR_MIN) ? ctr : ctr - ONE;
    end
  end

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int unsigned AW    = 6,
  parameter int unsigned CTR_W = 2,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rd_a_idx,
  output logic [CTR_W-1:0] rd_a_ctr,
  input  logic [AW-1:0]    rd_b_idx,
  output logic [CTR_W-1:0] rd_b_ctr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [CTR_W-1:0] wr_ctr
);

  logic [CTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else if (wr_en) begin
      mem[wr_idx] <= wr_ctr;
    end
  end

  assign rd_a_ctr = mem[rd_a_idx];
  assign rd_b_ctr = mem[rd_b_idx];

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor #(
  parameter int unsigned PC_W     = 8,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned HIST_W   = 4,
  parameter int unsigned CTR_W    = 2,
  parameter bit          USE_ADDR = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int unsigned AW = bp_pkg::table_aw(IDX_W, HIST_W, USE_ADDR);

  logic [HIST_W-1:0] hist_q;
  logic [AW-1:0]     pred_idx;
  logic [AW-1:0]     upd_idx;
  logic [CTR_W-1:0]  pred_ctr;
  logic [CTR_W-1:0]  upd_ctr;
  logic [CTR_W-1:0]  upd_next;

  bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid),
    .outcome  (upd_taken),
    .hist_q   (hist_q)
  );

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .USE_ADDR(USE_ADDR)) u_pred_index (
    .pc   (pred_pc),
    .hist (hist_q),
    .idx  (pred_idx)
  );

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .USE_ADDR(USE_ADDR)) u_upd_index (
    .pc   (upd_pc),
    .hist (hist_q),
    .idx  (upd_idx)
  );

  bp_ctr_table #(.AW(AW), .CTR_W(CTR_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (pred_idx),
    .rd_a_ctr (pred_ctr),
    .rd_b_idx (upd_idx),
    .rd_b_ctr (upd_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_ctr   (upd_next)
  );

  bp_sat_counter #(.CTR_W(CTR_W)) u_step (
    .ctr      (upd_ctr),
    .taken    (upd_taken),
    .ctr_next (upd_next)
  );

  assign pred_taken = (pred_ctr[CTR_W-1] == bp_pkg::DIR_TAKEN);

endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
  parameter int unsigned HIST_W = 4,
  parameter int unsigned CTR_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist,
  input logic [CTR_W-1:0]  upd_ctr,
  input logic [CTR_W-1:0]  upd_next
);

  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] ONE     = {{(CTR_W-1){1'b0}}, 1'b1};

  assert_hist_cleared_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hist == '0));

  assert_hist_shift_R4: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (hist == {$past(hist[HIST_W-2:0]), $past(upd_taken)}));

  assert_hist_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(hist));

  assert_ctr_up_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && (upd_ctr != CTR_MAX)) |-> (upd_next == upd_ctr + ONE));

  assert_ctr_top_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && (upd_ctr == CTR_MAX)) |-> (upd_next == CTR_MAX));

  assert_ctr_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && (upd_ctr == '0)) |-> (upd_next == '0));

endmodule

bind bp_predictor bp_predictor_chk #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .upd_valid (upd_valid),
  .upd_taken (upd_taken),
  .hist      (hist_q),
  .upd_ctr   (upd_ctr),
  .upd_next  (upd_next)
);

// File: tb/test_bp_predictor.sv
module test_bp_predictor;

  localparam int PC_W = 8;
  localparam int NVEC = 13;

  // each vector: {pc[7:0], outcome, expected prediction before update}
  localparam logic [9:0] VEC [NVEC] = '{
    {8'd0, 1'b1, 1'b0}, {8'd0, 1'b0, 1'b0}, {8'd0, 1'b1, 1'b0},
    {8'd0, 1'b0, 1'b0}, {8'd0, 1'b1, 1'b0}, {8'd0, 1'b0, 1'b0},
    {8'd0, 1'b1, 1'b0}, {8'd0, 1'b0, 1'b0}, {8'd0, 1'b1, 1'b1},
    {8'd0, 1'b0, 1'b0}, {8'd0, 1'b1, 1'b1}, {8'd0, 1'b1, 1'b0},
    {8'd0, 1'b0, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_taken;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bp_predictor i_bp_predictor (
    .clk        (clk),
    .rst        (rst),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_upd(input logic [PC_W-1:0] pc, input logic t);
    @(negedge clk);
    upd_pc = pc;
    upd_taken = t;
    upd_valid = 1'b1;
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  task automatic peek(input logic [PC_W-1:0] pc, input logic exp, input string tag);
    @(negedge clk);
    pred_pc = pc;
    #2 check(tag, pred_taken, exp);
  endtask

  // one taken, then HIST_W not-taken: history returns to zero, counter at history 0 moves up
  task automatic bump_zero(input logic [PC_W-1:0] pc);
    do_upd(pc, 1'b1);
    for (int k = 0; k < 4; k++) do_upd(pc, 1'b0);
  endtask

  task automatic idle(input int n, input logic t);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      upd_valid = 1'b0;
      upd_taken = t;
      upd_pc = 8'd0;
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: everything predicts not taken after reset
    for (int a = 0; a < 4; a++) peek(a[PC_W-1:0], 1'b0, "R1 reset prediction");

    // R8 / R2 / R6: alternating stream from the table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      pred_pc   = VEC[v][9:2];
      upd_pc    = VEC[v][9:2];
      upd_taken = VEC[v][1];
      upd_valid = 1'b1;
      #2 check($sformatf("R8 vector %0d", v), pred_taken, VEC[v][0]);
      @(posedge clk);
      #1 upd_valid = 1'b0;
    end

    do_reset();
    peek(8'd0, 1'b0, "R1 reset after training");

    // R4: taken outcome five updates old is outside the window
    bump_zero(8'd0);
    peek(8'd0, 1'b0, "R2 counter 1 predicts not taken");
    bump_zero(8'd0);
    peek(8'd0, 1'b1, "R4 counter 2 at history 0 predicts taken");

    // R7: invalid updates change nothing
    idle(3, 1'b0);
    peek(8'd0, 1'b1, "R7 idle not-taken strobes");
    idle(3, 1'b1);
    peek(8'd0, 1'b1, "R7 idle taken strobes");

    // R3: saturation at both ends
    bump_zero(8'd0);
    peek(8'd0, 1'b1, "R3 counter 3");
    bump_zero(8'd0);
    do_upd(8'd0, 1'b0);
    peek(8'd0, 1'b1, "R3 top saturation then one step down");
    do_upd(8'd0, 1'b0);
    peek(8'd0, 1'b0, "R3 second step down");
    for (int k = 0; k < 3; k++) do_upd(8'd0, 1'b0);
    peek(8'd0, 1'b0, "R3 bottom saturation");

    // R5 / R9: address separation and aliasing, same-cycle lookups
    bump_zero(8'd1);
    bump_zero(8'd1);
    @(negedge clk);
    pred_pc = 8'd1;
    #2 check("R9 pc1 same cycle", pred_taken, 1'b1);
    pred_pc = 8'd0;
    #2 check("R5 pc0 separate counter", pred_taken, 1'b0);
    pred_pc = 8'd5;
    #2 check("R5 pc5 aliases pc1", pred_taken, 1'b1);
    pred_pc = 8'd2;
    #2 check("R5 pc2 separate counter", pred_taken, 1'b0);

    // R6: collision shows the pre-update value
    @(negedge clk);
    pred_pc = 8'd1;
    upd_pc = 8'd1;
    upd_taken = 1'b0;
    upd_valid = 1'b1;
    #2 check("R6 collision pre-update", pred_taken, 1'b1);
    @(posedge clk);
    #1 upd_valid = 1'b0;
    peek(8'd1, 1'b0, "R6 after collision update");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule